// File: doc/BRIEF.md
# Windowed Watchdog Timer with Postscaler

This block is a watchdog timer driven by an already prescaled tick pulse. A programmable postscaler sets the timeout period to 2^n ticks, with n from 0 to 20. Software has to strobe the clear input before the period runs out. If it does not, the block raises a single-cycle reset request and starts a new period.

In windowed mode a clear is only legal during the final part of the period. The window can be 75 %, 50 %, 37.5 % or 25 % of the period. A clear that arrives before the window opens is treated as a fault and raises the reset request at once. A flag output tells software when a clear would be accepted. The watchdog can be forced on by configuration or switched on by a software bit. It can also be told to freeze its count while flash programming is busy.

Control is a three-state machine:
- IDLE: the watchdog is off and the count is held at zero.
- RUN: ticks are counted.
- BITE: the one cycle in which the reset request is high.

The transitions are:
- IDLE to RUN (enable rises).
- RUN to IDLE (enable falls).
- RUN to RUN with restart (accepted clear).
- RUN to BITE (timeout, or early clear).
- BITE to RUN (still enabled).
- BITE to IDLE (enable gone).

Top module: `win_watchdog`

## Requirements
- R1: After reset, `reset_req_o` is 0, `window_open_o` is 1 and the watchdog is in IDLE with a count of zero.
- R2: The watchdog runs when `cfg_force_on_i` is 1 or `sw_enable_i` is 1. When both are 0 it stays in IDLE: ticks and clears have no effect, no reset request is raised, and the count is held at zero. The state moves IDLE to RUN on the edge after enable rises, and ticks on that edge are not counted.
- R3: With postscale code n (0 to 20) the period is P = 2^n accepted ticks. On the edge that takes the P-th tick since the last restart, the state moves to BITE, `reset_req_o` is 1 for exactly one cycle, and the count restarts from zero. If the count is already at or above P-1 (after the code is lowered), the next accepted tick times out.
- R4: Postscale codes 21 to 31 behave exactly like code 20 (P = 1048576).
- R5: In windowed mode (`window_off_i` = 0), the window opens once the count reaches floor(P*k). The code `window_sel_i` sets k: 00 gives k = 1/4 (75 % window), 01 gives 1/2 (50 %), 10 gives 5/8 (37.5 %), and 11 gives 3/4 (25 %). While RUN, `window_open_o` equals (count >= that threshold).
- R6: A clear while RUN with the window open restarts the count from zero and raises no reset request.
- R7: A clear while RUN with the window closed moves to BITE. `reset_req_o` is 1 in the next cycle, for one cycle, and the count restarts.
- R8: With `window_off_i` = 1 (standard mode), `window_open_o` is always 1 and a clear at any count is accepted.
- R9: When `pgm_stall_i` = 1 and `flash_busy_i` = 1, ticks are not counted. When `pgm_stall_i` = 0, ticks are counted regardless of `flash_busy_i`.
- R10: A clear and a tick on the same edge act as a clear alone. In the BITE cycle, ticks and clears are ignored and counting resumes from zero.
- R11: Outside RUN (IDLE or BITE), `window_open_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled count pulse, one clock wide |
| clear_i | input | 1 | Software clear strobe |
| cfg_force_on_i | input | 1 | Configuration: 1 forces the watchdog on |
| sw_enable_i | input | 1 | Software enable, used when not forced on |
| window_off_i | input | 1 | 1 selects standard mode, 0 selects windowed mode |
| window_sel_i | input | 2 | Window size code (see R5) |
| post_sel_i | input | PS_W (5) | Postscale code n, period 2^n ticks |
| pgm_stall_i | input | 1 | 1 freezes counting while flash programming is busy |
| flash_busy_i | input | 1 | Flash programming in progress |
| reset_req_o | output | 1 | One-cycle reset request |
| window_open_o | output | 1 | A clear would currently be accepted |

## Verification
Short periods (codes 0 to 5) are driven with a continuous tick so that each timeout lands on a known edge. This separates an off-by-one in the period from a correct restart. Clears are placed just below and exactly at the window threshold for each size code, which tells an early-clear fault apart from an accepted clear. Coincident tick-and-clear, freezing with the stall bit set against flash busy alone, and out-of-range postscale codes are each driven directly. A long random phase then mixes every input, including configuration changes in mid-period, and compares both outputs every cycle against a cycle model in the bench.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        WIN_75   = 2'b00,
        WIN_50   = 2'b01,
        WIN_37P5 = 2'b10,
        WIN_25   = 2'b11
    } win_size_e;

endpackage

// File: rtl/wdt_span_decode.sv
module wdt_span_decode #(
    parameter int PS_W     = 5,
    parameter int MAX_CODE = 20,
    parameter int CNT_W    = MAX_CODE
) (
    input  logic [PS_W-1:0]  ps_code_i,
    input  logic [1:0]       win_sel_i,
    output logic [CNT_W-1:0] last_o,
    output logic [CNT_W-1:0] thr_o
);
    import wdt_pkg::*;

    localparam int PER_W = CNT_W + 1;

    logic [PS_W-1:0]  eff_code;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] thr_wide;
    win_size_e        win_sel;

    assign win_sel = win_size_e'(win_sel_i);

    // Codes above the top ratio saturate at the top ratio.
    always_comb begin
        if (ps_code_i > PS_W'(MAX_CODE)) begin
            eff_code = PS_W'(MAX_CODE);
        end else begin
            eff_code = ps_code_i;
        end
    end

    assign period = PER_W'(1) << eff_code;
    assign last_o = CNT_W'(period - PER_W'(1));

    // The window opens at period minus window length, built from shifts.
    always_comb begin
        unique case (win_sel)
            WIN_75:   thr_wide = period >> 2;
            WIN_50:   thr_wide = period >> 1;
            WIN_37P5: thr_wide = (period >> 1) + (period >> 3);
            WIN_25:   thr_wide = (period >> 1) + (period >> 2);
            default:  thr_wide = period >> 1;
        endcase
    end

    assign thr_o = CNT_W'(thr_wide);

    // R5
    always_comb begin
        span_order_chk: assert (thr_o <= last_o || $isunknown(ps_code_i) || $isunknown(win_sel_i));
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] last_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_end_o,
    output logic             in_win_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o    = cnt_q;
    assign at_end_o = (cnt_q >= last_i);
    assign in_win_o = (cnt_q >= thr_i);

    // R2
    property clr_zero_p;
        @(posedge clk) disable iff (!rst_n) clr_i |=> (cnt_q == '0);
    endproperty
    clr_zero_chk: assert property (clr_zero_p);

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
    parameter int PS_W     = 5,
    parameter int MAX_CODE = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            clear_i,
    input  logic            cfg_force_on_i,
    input  logic            sw_enable_i,
    input  logic            window_off_i,
    input  logic [1:0]      window_sel_i,
    input  logic [PS_W-1:0] post_sel_i,
    input  logic            pgm_stall_i,
    input  logic            flash_busy_i,
    output logic            reset_req_o,
    output logic            window_open_o
);
    import wdt_pkg::*;

    localparam int CNT_W = MAX_CODE;

    wd_state_e        state_q;
    wd_state_e        state_d;
    logic             en;
    logic             hold;
    logic             adv;
    logic             cnt_clr;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] thr_val;
    logic [CNT_W-1:0] cnt;
    logic             at_end;
    logic             in_win;
    logic             clr_ok;

    assign en   = cfg_force_on_i | sw_enable_i;
    assign hold = pgm_stall_i & flash_busy_i;
    assign adv  = tick_i & ~hold;

    wdt_span_decode #(
        .PS_W     (PS_W),
        .MAX_CODE (MAX_CODE),
        .CNT_W    (CNT_W)
    ) i_span (
        .ps_code_i (post_sel_i),
        .win_sel_i (window_sel_i),
        .last_o    (last_val),
        .thr_o     (thr_val)
    );

    // Count is only live in RUN; a clear or timeout restarts it.
    assign cnt_clr = (state_q != WD_RUN) | ~en | clear_i | (adv & at_end);

    wdt_tick_counter #(
        .CNT_W (CNT_W)
    ) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cnt_clr),
        .inc_i    (adv),
        .last_i   (last_val),
        .thr_i    (thr_val),
        .cnt_o    (cnt),
        .at_end_o (at_end),
        .in_win_o (in_win)
    );

    assign clr_ok = window_off_i | in_win;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (en) begin
                    state_d = WD_RUN;
                end
            end
            WD_RUN: begin
                if (!en) begin
                    state_d = WD_IDLE;
                end else if (clear_i) begin
                    state_d = clr_ok ? WD_RUN : WD_BITE;
                end else if (adv && at_end) begin
                    state_d = WD_BITE;
                end
            end
            WD_BITE: begin
                state_d = en ? WD_RUN : WD_IDLE;
            end
            default: state_d = WD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        reset_req_o   = 1'b0;
        window_open_o = 1'b1;
        unique case (state_q)
            WD_IDLE: begin
                reset_req_o   = 1'b0;
                window_open_o = 1'b1;
            end
            WD_RUN: begin
                reset_req_o   = 1'b0;
                window_open_o = clr_ok;
            end
            WD_BITE: begin
                reset_req_o   = 1'b1;
                window_open_o = 1'b1;
            end
            default: begin
                reset_req_o   = 1'b0;
                window_open_o = 1'b1;
            end
        endcase
    end

    // R3
    property pulse_one_p;
        @(posedge clk) disable iff (!rst_n) reset_req_o |=> !reset_req_o;
    endproperty
    pulse_one_chk: assert property (pulse_one_p);

    // R2
    property needs_enable_p;
        @(posedge clk) disable iff (!rst_n) reset_req_o |-> $past(en);
    endproperty
    needs_enable_chk: assert property (needs_enable_p);

    // R3
    property timeout_bite_p;
        @(posedge clk) disable iff (!rst_n)
            (state_q == WD_RUN && en && !clear_i && adv && at_end) |=> reset_req_o;
    endproperty
    timeout_bite_chk: assert property (timeout_bite_p);

    // R7
    property early_bite_p;
        @(posedge clk) disable iff (!rst_n)
            (state_q == WD_RUN && en && clear_i && !window_open_o) |=> reset_req_o;
    endproperty
    early_bite_chk: assert property (early_bite_p);

    // R6
    property good_clear_p;
        @(posedge clk) disable iff (!rst_n)
            (state_q == WD_RUN && en && clear_i && window_open_o) |=> (!reset_req_o && cnt == '0);
    endproperty
    good_clear_chk: assert property (good_clear_p);

    // R9
    property freeze_p;
        @(posedge clk) disable iff (!rst_n)
            (state_q == WD_RUN && en && hold && !clear_i) |=> $stable(cnt);
    endproperty
    freeze_chk: assert property (freeze_p);

    // R11
    property idle_open_p;
        @(posedge clk) disable iff (!rst_n) (state_q != WD_RUN) |-> window_open_o;
    endproperty
    idle_open_chk: assert property (idle_open_p);

endmodule

// File: tb/test_win_watchdog.sv
module test_win_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       clr = 1'b0;
    logic       force_on = 1'b0;
    logic       sw_on = 1'b0;
    logic       win_off = 1'b1;
    logic [1:0] win_sel = 2'b00;
    logic [4:0] ps_sel = 5'd0;
    logic       stall = 1'b0;
    logic       busy = 1'b0;
    logic       rst_req;
    logic       win_open;

    int total = 0;
    int bad = 0;
    int rst_seen = 0;

    // cycle model: 0 idle, 1 run, 2 bite
    int     m_state = 0;
    longint m_cnt = 0;
    string  m_tag = "R3";

    always #10 clk = ~clk;

    win_watchdog i_win_watchdog (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .clear_i        (clr),
        .cfg_force_on_i (force_on),
        .sw_enable_i    (sw_on),
        .window_off_i   (win_off),
        .window_sel_i   (win_sel),
        .post_sel_i     (ps_sel),
        .pgm_stall_i    (stall),
        .flash_busy_i   (busy),
        .reset_req_o    (rst_req),
        .window_open_o  (win_open)
    );

    function automatic int eff(input int code);
        return (code > 20) ? 20 : code;
    endfunction

    function automatic longint thr_of(input int c, input int ws);
        longint p;
        p = longint'(1) << c;
        case (ws)
            0: return p / 4;
            1: return p / 2;
            2: return (p * 5) / 8;
            default: return (p * 3) / 4;
        endcase
    endfunction

    function automatic bit exp_win();
        if (m_state != 1) return 1'b1;
        if (win_off) return 1'b1;
        return m_cnt >= thr_of(eff(int'(ps_sel)), int'(win_sel));
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit en;
        bit adv;
        bit open;
        longint last;
        en   = force_on | sw_on;
        adv  = tick && !(stall && busy);
        last = (longint'(1) << eff(int'(ps_sel))) - 1;
        open = win_off || (m_cnt >= thr_of(eff(int'(ps_sel)), int'(win_sel)));
        case (m_state)
            0: begin
                m_cnt = 0;
                if (en) m_state = 1;
            end
            1: begin
                if (!en) begin
                    m_state = 0;
                    m_cnt = 0;
                end else if (clr) begin
                    m_cnt = 0;
                    if (!open) begin
                        m_state = 2;
                        m_tag = "R7";
                    end
                end else if (adv) begin
                    if (m_cnt >= last) begin
                        m_state = 2;
                        m_cnt = 0;
                        m_tag = "R3";
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
            end
            default: begin
                m_cnt = 0;
                m_state = en ? 1 : 0;
            end
        endcase
    endtask

    // One clock: inputs already set; model follows the edge; sample at negedge.
    task automatic cyc();
        bit ew;
        @(posedge clk);
        model_step();
        @(negedge clk);
        ew = exp_win();
        check(rst_req == (m_state == 2), (m_state == 2) ? m_tag : "R3", "reset_req",
              longint'(rst_req), longint'(m_state == 2));
        check(win_open == ew, win_off ? "R8" : ((m_state != 1) ? "R11" : "R5"), "window_open",
              longint'(win_open), longint'(ew));
        if (rst_req) rst_seen++;
    endtask

    task automatic restart();
        force_on = 1'b0;
        sw_on = 1'b0;
        clr = 1'b0;
        tick = 1'b0;
        cyc();
        force_on = 1'b1;
        cyc();
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rst_req == 1'b0, "R1", "reset_req in reset", longint'(rst_req), 0);
        check(win_open == 1'b1, "R1", "window_open in reset", longint'(win_open), 1);
        rst_n = 1'b1;
        cyc();
        check(rst_req == 1'b0, "R1", "reset_req after reset", longint'(rst_req), 0);

        // R3: code 3, P=8, continuous tick
        win_off = 1'b1;
        ps_sel = 5'd3;
        tick = 1'b1;
        force_on = 1'b1;
        rst_seen = 0;
        repeat (9) cyc();
        check(rst_req == 1'b1, "R3", "timeout on 8th tick", longint'(rst_req), 1);
        check(rst_seen == 1, "R3", "single pulse", rst_seen, 1);
        rst_seen = 0;
        repeat (8) cyc();
        check(rst_seen == 0, "R10", "bite cycle ignores tick", rst_seen, 0);
        cyc();
        check(rst_req == 1'b1, "R3", "second period", longint'(rst_req), 1);

        // R5: window 37.5% with P=8 opens at count 5
        win_off = 1'b0;
        win_sel = 2'b10;
        restart();
        tick = 1'b1;
        repeat (4) cyc();
        tick = 1'b0;
        cyc();
        check(win_open == 1'b0, "R5", "closed at count 4", longint'(win_open), 0);
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        cyc();
        check(win_open == 1'b1, "R5", "open at count 5", longint'(win_open), 1);

        // R6: clear inside window
        clr = 1'b1;
        cyc();
        clr = 1'b0;
        check(rst_req == 1'b0, "R6", "good clear no reset", longint'(rst_req), 0);
        check(win_open == 1'b0, "R6", "count restarted", longint'(win_open), 0);

        // R7: clear before window
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        clr = 1'b1;
        cyc();
        clr = 1'b0;
        check(rst_req == 1'b1, "R7", "early clear bites", longint'(rst_req), 1);
        cyc();
        check(rst_req == 1'b0, "R7", "bite lasts one cycle", longint'(rst_req), 0);

        // R5: 75% window, P=8 opens at 2
        win_sel = 2'b00;
        restart();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        check(win_open == 1'b0, "R5", "75pct closed at 1", longint'(win_open), 0);
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        check(win_open == 1'b1, "R5", "75pct open at 2", longint'(win_open), 1);

        // R8: standard mode accepts clear at count 1
        win_off = 1'b1;
        restart();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        check(win_open == 1'b1, "R8", "standard mode open", longint'(win_open), 1);
        clr = 1'b1;
        cyc();
        clr = 1'b0;
        check(rst_req == 1'b0, "R8", "clear anytime", longint'(rst_req), 0);

        // R10: tick and clear together, P=2
        ps_sel = 5'd1;
        restart();
        tick = 1'b1;
        cyc();
        clr = 1'b1;
        cyc();
        clr = 1'b0;
        check(rst_req == 1'b0, "R10", "clear wins over tick", longint'(rst_req), 0);
        cyc();
        check(rst_req == 1'b0, "R10", "count 1 after clear", longint'(rst_req), 0);
        cyc();
        check(rst_req == 1'b1, "R10", "timeout after restart", longint'(rst_req), 1);

        // R9: freeze while programming
        ps_sel = 5'd2;
        restart();
        stall = 1'b1;
        busy = 1'b1;
        tick = 1'b1;
        rst_seen = 0;
        repeat (12) cyc();
        check(rst_seen == 0, "R9", "frozen count", rst_seen, 0);
        stall = 1'b0;
        repeat (4) cyc();
        check(rst_req == 1'b1, "R9", "runs when stall bit clear", longint'(rst_req), 1);
        busy = 1'b0;

        // R2: disabled ignores ticks and clears
        force_on = 1'b0;
        sw_on = 1'b0;
        ps_sel = 5'd0;
        rst_seen = 0;
        for (int k = 0; k < 20; k++) begin
            clr = (k % 5 == 0);
            cyc();
        end
        clr = 1'b0;
        check(rst_seen == 0, "R2", "no reset while off", rst_seen, 0);
        win_off = 1'b0;
        check(win_open == 1'b1, "R11", "open while idle", longint'(win_open), 1);
        win_off = 1'b1;
        ps_sel = 5'd2;
        sw_on = 1'b1;
        repeat (5) cyc();
        check(rst_req == 1'b1, "R2", "software enable runs", longint'(rst_req), 1);

        // R4: codes above 20 saturate
        for (int code = 21; code < 32; code += 10) begin
            ps_sel = 5'(code);
            win_off = 1'b0;
            win_sel = 2'b11;
            restart();
            tick = 1'b1;
            rst_seen = 0;
            repeat (300) cyc();
            tick = 1'b0;
            check(rst_seen == 0, "R4", "no early timeout", rst_seen, 0);
            check(win_open == 1'b0, "R4", "window still closed", longint'(win_open), 0);
        end

        // Random phase
        for (int n = 0; n < 6000; n++) begin
            tick = 1'($urandom % 2);
            clr = (($urandom % 12) == 0);
            if (($urandom % 48) == 0) begin
                ps_sel = (($urandom % 8) == 0) ? 5'(21 + $urandom % 11) : 5'($urandom % 6);
                win_sel = 2'($urandom % 4);
                win_off = 1'($urandom % 2);
                force_on = (($urandom % 4) != 0);
                sw_on = 1'($urandom % 2);
                stall = 1'($urandom % 2);
            end
            busy = (($urandom % 4) == 0);
            cyc();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule